// File: doc/BRIEF.md
# Max-Log-MAP Soft-Output and Extrinsic Unit

This block finishes one trellis step of an 8-state turbo decoder using the max-log approximation. On every accepted step it receives the eight forward state metrics, the eight backward state metrics and four branch metrics (one per systematic/parity codeword). From these it builds a candidate metric for each of the sixteen trellis branches and takes the best candidate among branches driven by input 1 and among branches driven by input 0. The difference between the two is the a posteriori log-likelihood ratio.

It then subtracts the channel systematic value and the a priori value from the ratio at full width, clips the result into a six-bit 4.2 fixed-point word, and stores both the ratio and the clipped extrinsic value. The steps of a window arrive last-to-first, because the backward recursion runs from the end of the window. Two buffer banks turn each window around into first-to-last order. One bank fills while the other drains, so windows can follow each other with no gap.

Top module: `maxlog_llr_unit`

## Requirements
- R1: While reset is held and after it is released, `out_valid` stays low until a window has been closed with an accepted `win_end`.
- R2: Branch candidates come from the trellis. State `s` has bits s[2] (newest) down to s[0]. For input `u`, the feedback bit is fb = u^s[1]^s[0], the next state is {fb,s[2],s[1]} and the parity bit is p = fb^s[2]^s[0]. The candidate for branch (s,u) is alpha[s] + gamma[2u+p] + beta[next]. Metric `k` occupies bits [k*W +: W] of its bus.
- R3: `out_llr` is the largest candidate with u=1 minus the largest candidate with u=0, as an 11-bit two's-complement value.
- R4: State metrics are modulo values. Comparisons use the sign of the wrapped 11-bit difference, so results stay correct when metrics wrap past 2^11, provided the true spread of the candidates stays below 1024.
- R5: The extrinsic value is the ratio minus `sys_in` minus `apr_in`, all signed and computed at a width that cannot overflow.
- R6: `out_ext` is 6-bit two's complement with 2 fractional bits. A value above 31 (+7.75) is output as 31, a value below -32 (-8.00) is output as -32, and values in range pass unchanged.
- R7: A window of N accepted steps, the last carrying `win_end`=1, is output in reverse order of arrival. The outputs appear on N consecutive cycles, and the first appears two clock edges after the edge that accepted `win_end`.
- R8: A new window may fill while the previous one drains. If it closes on the last drain cycle of the previous window, output continues with no gap.
- R9: When `in_valid` is low, all inputs, `win_end` included, are ignored. Nothing is stored and the output stream is unaffected.
- R10: A window may hold up to WIN steps (default 20), and windows of 1 and of WIN steps both work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies one trellis step |
| win_end | input | 1 | Marks the last step of a window (backward order) |
| alpha_in | input | 88 | Eight forward state metrics, 11 bits each, modulo |
| beta_in | input | 88 | Eight backward state metrics, 11 bits each, modulo |
| gamma_in | input | 36 | Four signed branch metrics, 9 bits each, index 2u+p |
| sys_in | input | 8 | Signed channel systematic value |
| apr_in | input | 8 | Signed a priori value |
| out_valid | output | 1 | Output step valid |
| out_llr | output | 11 | A posteriori ratio, signed |
| out_ext | output | 6 | Clipped extrinsic value, 4.2 format |

## Verification
On every accepted step, the assertions check that each selected maximum is not beaten by any candidate of its class under the wrapped comparison. They also check that an idle cycle leaves the fill pointer and bank alone, that a closed window starts output two edges later, and that drains end only at the bottom of the window. They also check legal use: no window longer than WIN, and no window closing while the previous drain still has entries. The bench scenarios show what only a full stream reveals. These are the exact ratio and clipped value against an independent max-log model, including metrics that wrap past 2^11. They also cover the saturation boundaries at 31/32 and -32/-33, the reversed order and timing of each window, back-to-back windows, steps interleaved with ignored idle cycles, and windows of length 1 and 20.

// File: rtl/maxlog_llr_unit.sv
module maxlog_llr_unit #(
  parameter int SM_W  = 11,
  parameter int BM_W  = 9,
  parameter int IN_W  = 8,
  parameter int EXT_W = 6,
  parameter int WIN   = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 win_end,
  input  logic [8*SM_W-1:0]    alpha_in,
  input  logic [8*SM_W-1:0]    beta_in,
  input  logic [4*BM_W-1:0]    gamma_in,
  input  logic [IN_W-1:0]      sys_in,
  input  logic [IN_W-1:0]      apr_in,
  output logic                 out_valid,
  output logic [SM_W-1:0]      out_llr,
  output logic [EXT_W-1:0]     out_ext
);
  localparam int NS = 8;
  localparam int NB = 2 * NS;
  localparam int XW = SM_W + 2;
  localparam int DW = SM_W + EXT_W;
  localparam int PW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int IW = $clog2(2 * WIN);

  function automatic logic [2:0] br_next(input logic [2:0] s, input logic u);
    logic fb;
    fb = u ^ s[1] ^ s[0];
    return {fb, s[2], s[1]};
  endfunction

  function automatic logic [1:0] br_cls(input logic [2:0] s, input logic u);
    logic fb;
    fb = u ^ s[1] ^ s[0];
    return {u, fb ^ s[2] ^ s[0]};
  endfunction

  function automatic logic [SM_W-1:0] wmax(input logic [SM_W-1:0] a, input logic [SM_W-1:0] b);
    logic [SM_W-1:0] d;
    d = a - b;
    return d[SM_W-1] ? b : a;
  endfunction

  logic [SM_W-1:0] am [NS];
  logic [SM_W-1:0] bm [NS];
  logic [SM_W-1:0] gx [4];
  logic [SM_W-1:0] cand [NB];
  logic [SM_W-1:0] max1, max0, llr;

  for (genvar k = 0; k < NS; k++) begin : g_unpack
    assign am[k] = alpha_in[k*SM_W +: SM_W];
    assign bm[k] = beta_in[k*SM_W +: SM_W];
  end
  for (genvar k = 0; k < 4; k++) begin : g_gamma
    assign gx[k] = SM_W'($signed(gamma_in[k*BM_W +: BM_W]));
  end

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      for (int u = 0; u < 2; u++) begin
        cand[2*s+u] = am[s] + gx[br_cls(3'(s), 1'(u))] + bm[br_next(3'(s), 1'(u))];
      end
    end
    max1 = cand[1];
    max0 = cand[0];
    for (int s = 1; s < NS; s++) begin
      max1 = wmax(max1, cand[2*s+1]);
      max0 = wmax(max0, cand[2*s]);
    end
  end

  assign llr = max1 - max0;

  logic signed [XW-1:0] ext_full;
  logic [XW-EXT_W:0]    ext_hi;
  logic                 ext_ovf;
  logic [EXT_W-1:0]     ext_sat;

  assign ext_full = XW'($signed(llr)) - XW'($signed(sys_in)) - XW'($signed(apr_in));
  assign ext_hi   = ext_full[XW-1:EXT_W-1];
  assign ext_ovf  = (|ext_hi) && !(&ext_hi);
  assign ext_sat  = !ext_ovf ? ext_full[EXT_W-1:0]
                  : (ext_full[XW-1] ? {1'b1, {(EXT_W-1){1'b0}}} : {1'b0, {(EXT_W-1){1'b1}}});

  logic [DW-1:0] mem [2*WIN];
  logic          fill_bank, drain_active;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [IW-1:0] wa, ra;
  logic [DW-1:0] out_data;

  assign wa = fill_bank ? IW'(WIN) + IW'(wr_ptr) : IW'(wr_ptr);
  assign ra = fill_bank ? IW'(rd_ptr) : IW'(WIN) + IW'(rd_ptr);

  always_ff @(posedge clk) begin
    if (in_valid) mem[wa] <= {llr, ext_sat};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_bank    <= 1'b0;
      drain_active <= 1'b0;
      wr_ptr       <= '0;
      rd_ptr       <= '0;
      out_valid    <= 1'b0;
      out_data     <= '0;
    end else begin
      out_valid <= drain_active;
      if (drain_active) begin
        out_data <= mem[ra];
        if (rd_ptr == '0) drain_active <= 1'b0;
        else              rd_ptr <= rd_ptr - 1'b1;
      end
      if (in_valid) begin
        if (win_end) begin
          fill_bank    <= ~fill_bank;
          wr_ptr       <= '0;
          rd_ptr       <= wr_ptr;
          drain_active <= 1'b1;
        end else begin
          wr_ptr <= wr_ptr + 1'b1;
        end
      end
    end
  end

  assign out_llr = out_data[DW-1:EXT_W];
  assign out_ext = out_data[EXT_W-1:0];

  for (genvar k = 0; k < NS; k++) begin : g_chk_max
    logic [SM_W-1:0] d1, d0;
    assign d1 = max1 - cand[2*k+1];
    assign d0 = max0 - cand[2*k];
    p_max1_r3: assert property (@(posedge clk) disable iff (!rst_n) in_valid |-> !d1[SM_W-1]);
    p_max0_r4: assert property (@(posedge clk) disable iff (!rst_n) in_valid |-> !d0[SM_W-1]);
  end

  p_drain_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && win_end) |-> ##2 out_valid);
  p_drain_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drain_active) |-> ($past(rd_ptr) == '0));
  p_no_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && win_end && drain_active) |-> (rd_ptr == '0));
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(wr_ptr) && $stable(fill_bank)));
  p_win_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !win_end) |-> (wr_ptr < PW'(WIN-1)));
endmodule

// File: tb/maxlog_llr_unit_bench.sv
module maxlog_llr_unit_bench;
  localparam int WIN = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        win_end = 1'b0;
  logic [87:0] alpha_in = '0;
  logic [87:0] beta_in = '0;
  logic [35:0] gamma_in = '0;
  logic [7:0]  sys_in = '0;
  logic [7:0]  apr_in = '0;
  logic        out_valid;
  logic [10:0] out_llr;
  logic [5:0]  out_ext;

  maxlog_llr_unit #(.WIN(WIN)) u_maxlog_llr_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .win_end(win_end),
    .alpha_in(alpha_in), .beta_in(beta_in), .gamma_in(gamma_in),
    .sys_in(sys_in), .apr_in(apr_in),
    .out_valid(out_valid), .out_llr(out_llr), .out_ext(out_ext));

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  int seed = 12345;
  int a_rel [8], b_rel [8], g_rel [4];
  int sysv, aprv, base_a, base_b;
  int exp_llr [64], exp_ext [64], n_exp;
  int cap_llr [64], cap_ext [64], cap_cyc [64], cap_n;
  int end_cyc;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && out_valid && cap_n < 64) begin
      cap_llr[cap_n] = int'($signed(out_llr));
      cap_ext[cap_n] = int'($signed(out_ext));
      cap_cyc[cap_n] = cyc;
      cap_n++;
    end
  end

  always @(posedge clk) begin
    if (cyc > 50000 && !done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog: actual cyc=%0d expected <=50000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(int act, int expv, string tag);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int rnd(int range);
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 16) & 32'h7fff) % range;
  endfunction

  function automatic int nxt_state(int s, int u);
    int fb;
    fb = u ^ ((s >> 1) & 1) ^ (s & 1);
    return (fb << 2) | (((s >> 2) & 1) << 1) | ((s >> 1) & 1);
  endfunction

  function automatic int cls_idx(int s, int u);
    int fb;
    fb = u ^ ((s >> 1) & 1) ^ (s & 1);
    return 2 * u + (fb ^ ((s >> 2) & 1) ^ (s & 1));
  endfunction

  function automatic int model_llr();
    int m1, m0, c;
    m1 = -1000000; m0 = -1000000;
    for (int s = 0; s < 8; s++) begin
      for (int u = 0; u < 2; u++) begin
        c = a_rel[s] + g_rel[cls_idx(s, u)] + b_rel[nxt_state(s, u)];
        if (u == 1 && c > m1) m1 = c;
        if (u == 0 && c > m0) m0 = c;
      end
    end
    return m1 - m0;
  endfunction

  function automatic int clip(int x);
    if (x > 31) return 31;
    if (x < -32) return -32;
    return x;
  endfunction

  task automatic set_rand();
    for (int s = 0; s < 8; s++) begin
      a_rel[s] = rnd(256);
      b_rel[s] = rnd(256);
    end
    for (int k = 0; k < 4; k++) g_rel[k] = rnd(201) - 100;
    sysv = rnd(256) - 128;
    aprv = rnd(64) - 32;
  endtask

  task automatic set_zero(int s_val, int a_val);
    for (int s = 0; s < 8; s++) begin
      a_rel[s] = 0;
      b_rel[s] = 0;
    end
    for (int k = 0; k < 4; k++) g_rel[k] = 0;
    sysv = s_val;
    aprv = a_val;
  endtask

  task automatic drive(bit v, bit we);
    @(negedge clk);
    in_valid = v;
    win_end = we;
    for (int s = 0; s < 8; s++) begin
      alpha_in[s*11 +: 11] = 11'(base_a + a_rel[s]);
      beta_in[s*11 +: 11]  = 11'(base_b + b_rel[s]);
    end
    for (int k = 0; k < 4; k++) gamma_in[k*9 +: 9] = 9'(g_rel[k]);
    sys_in = 8'(sysv);
    apr_in = 8'(aprv);
    if (v) begin
      exp_llr[n_exp] = model_llr();
      exp_ext[n_exp] = clip(exp_llr[n_exp] - sysv - aprv);
      n_exp++;
      if (we) end_cyc = cyc;
    end
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 0;
      win_end = 0;
    end
  endtask

  task automatic begin_test(int ba, int bb);
    n_exp = 0;
    cap_n = 0;
    base_a = ba;
    base_b = bb;
  endtask

  task automatic check_group(int e0, int len, int c0, string tag);
    for (int i = 0; i < len; i++) begin
      chk(cap_llr[c0+i], exp_llr[e0+len-1-i], {tag, " R3 llr"});
      chk(cap_ext[c0+i], exp_ext[e0+len-1-i], {tag, " R5 ext"});
      chk(cap_cyc[c0+i], cap_cyc[c0] + i, {tag, " R7 consecutive"});
    end
  endtask

  task automatic run_window(int len, string tag);
    int e;
    for (int i = 0; i < len; i++) begin
      set_rand();
      drive(1, i == len - 1);
    end
    e = end_cyc;
    idle(len + 4);
    chk(cap_n, len, {tag, " R7 count"});
    chk(cap_cyc[0], e + 2, {tag, " R7 latency"});
    check_group(0, len, 0, tag);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (4) @(negedge clk);
    chk(int'(out_valid), 0, "R1 valid in reset");
    rst_n = 1;
    cap_n = 0;
    idle(6);
    chk(cap_n, 0, "R1 no output before window");
  endtask

  task automatic t_basic();
    begin_test(0, 37);
    run_window(6, "R2 basic");
  endtask

  task automatic t_single();
    begin_test(500, 100);
    run_window(1, "R7 single");
  endtask

  task automatic t_modulo();
    begin_test(2000, 1900);
    run_window(7, "R4 wrap");
  endtask

  task automatic t_sat();
    begin_test(0, 0);
    set_zero(-31, 0); drive(1, 0);
    set_zero(-32, 0); drive(1, 0);
    set_zero(32, 0);  drive(1, 0);
    set_zero(33, 0);  drive(1, 0);
    set_zero(-128, -128); drive(1, 0);
    set_zero(127, 127);   drive(1, 1);
    idle(10);
    chk(cap_n, 6, "R6 count");
    chk(cap_ext[5], 31, "R6 in-range +31");
    chk(cap_ext[4], 31, "R6 +32 clipped");
    chk(cap_ext[3], -32, "R6 in-range -32");
    chk(cap_ext[2], -32, "R6 -33 clipped");
    chk(cap_ext[1], 31, "R6 large positive");
    chk(cap_ext[0], -32, "R6 large negative");
    chk(cap_llr[0], 0, "R6 llr zero");
  endtask

  task automatic t_b2b();
    int e;
    begin_test(300, 1200);
    for (int i = 0; i < 4; i++) begin set_rand(); drive(1, i == 3); end
    e = end_cyc;
    for (int i = 0; i < 4; i++) begin set_rand(); drive(1, i == 3); end
    idle(10);
    chk(cap_n, 8, "R8 count");
    chk(cap_cyc[0], e + 2, "R8 first latency");
    check_group(0, 4, 0, "R8 windowA");
    check_group(4, 4, 4, "R8 windowB");
    chk(cap_cyc[4], cap_cyc[3] + 1, "R8 no gap");
  endtask

  task automatic t_ignore();
    begin_test(64, 640);
    set_rand(); drive(1, 0);
    set_rand(); drive(0, 1);
    set_rand(); drive(1, 0);
    set_rand(); drive(0, 0);
    set_rand(); drive(0, 1);
    set_rand(); drive(1, 0);
    idle(3);
    chk(cap_n, 0, "R9 no output from idle win_end");
    set_rand(); drive(1, 1);
    idle(8);
    chk(cap_n, 4, "R9 count");
    check_group(0, 4, 0, "R9 ignore");
  endtask

  task automatic t_full();
    begin_test(1500, 700);
    run_window(WIN, "R10 full");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_single();
    t_modulo();
    t_sat();
    t_b2b();
    t_ignore();
    t_full();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule